// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes in 32-bit command words sent over a three-wire serial link. The link has an active-low frame strobe, a serial clock and a data line. A frame opens when the strobe falls. The data line is sampled on each falling edge of the serial clock, most significant bit first. On the final (32nd) falling edge the completed word is presented on a parallel output, together with a valid pulse that lasts one system-clock cycle. The block does not decode the command.

All three serial inputs are brought into the faster system clock domain through flop synchronisers, and their edges are detected there. The system clock must run at no less than four times the serial clock rate.

After a frame completes, the receiver ignores further serial clock edges until the strobe has gone high and then fallen again. If the strobe rises before all bits have arrived, the frame is thrown away and no valid pulse is produced.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `valid_o` is 0 and `word_o` is 0 until the first complete frame.
- R2: The data line is sampled on each falling edge of `sclk_i` while a frame is open. The first bit becomes bit 31 of `word_o` and the last bit becomes bit 0.
- R3: Each complete frame produces exactly one `valid_o` pulse, one system cycle wide, and `word_o` changes only in that cycle.
- R4: If `strobe_n_i` rises after fewer than 32 falling edges, no pulse is produced, and the next full frame is received with no leftover bits from the cut frame.
- R5: Falling edges of `sclk_i` after the 32nd, while the strobe stays low, produce no pulse and leave `word_o` unchanged.
- R6: A new frame opens only on a falling edge of the strobe. A strobe that is low when reset is released, or that stays low after a completed frame, opens no frame.
- R7: The word completes on its 32nd falling edge even if the strobe rises in the same system cycle in which that edge is detected.
- R8: The serial inputs are sampled through two-flop synchronisers. Correct operation requires a system clock of at least four times the serial clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_n_i | input | 1 | Frame strobe, active low |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edges |
| sdata_i | input | 1 | Serial data, MSB first |
| word_o | output | 32 | Last completed word |
| valid_o | output | 1 | One-cycle pulse when `word_o` is updated |

## Verification
The hardest case to reach is a strobe rise that lands in the same synchronised cycle as the 32nd falling clock edge. Here a wrong priority would throw away a complete word. The bench reaches it by changing both pins in the same system-clock step, so both pass through identical synchroniser chains and are seen together. The other sweeps cut frames at every length from 1 to 31 bits, and hold the strobe low through extra clocks and through a whole second frame.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} state_t;

  logic [SYNC_STAGES-1:0] stb_q, sck_q, dat_q;
  logic                   stb_d, sck_d;
  logic [WORD_W-1:0]      shreg;
  logic [CNT_W-1:0]       cnt;
  state_t                 state;

  wire stb_s  = stb_q[SYNC_STAGES-1];
  wire sck_s  = sck_q[SYNC_STAGES-1];
  wire dat_s  = dat_q[SYNC_STAGES-1];
  wire stb_fall = stb_d & ~stb_s;
  wire sck_fall = sck_d & ~sck_s;
  wire [WORD_W-1:0] next_sh = {shreg[WORD_W-2:0], dat_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      sck_q <= '0;
      dat_q <= '0;
      stb_d <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      stb_q <= {stb_q[SYNC_STAGES-2:0], strobe_n_i};
      sck_q <= {sck_q[SYNC_STAGES-2:0], sclk_i};
      dat_q <= {dat_q[SYNC_STAGES-2:0], sdata_i};
      stb_d <= stb_s;
      sck_d <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (state)
        ST_IDLE: if (stb_fall) begin
          state <= ST_SHIFT;
          cnt   <= '0;
        end
        ST_SHIFT: if (sck_fall) begin
          shreg <= next_sh;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            word_o  <= next_sh;
            valid_o <= 1'b1;
            state   <= ST_DONE;
          end
        end else if (stb_s) begin
          state <= ST_IDLE;
        end
        ST_DONE: if (stb_s) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R3
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(word_o)); // R3
  AST_PULSE_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(state == ST_SHIFT)); // R6
  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> !valid_o); // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> !valid_o); // R4
endmodule

// File: tb/serial_frame_rx_bench.sv
module serial_frame_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [31:0] word;
  logic valid;
  int checks = 0, fails = 0, pulses = 0;
  logic [31:0] last_word = '0;

  always #2 clk = ~clk;

  serial_frame_rx u_serial_frame_rx (
    .clk(clk), .rst_n(rst_n), .strobe_n_i(strobe_n), .sclk_i(sclk),
    .sdata_i(sdata), .word_o(word), .valid_o(valid));

  always @(negedge clk) if (valid) begin
    pulses++;
    last_word = word;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b, input logic last_with_rise);
    sdata = b; sclk = 1'b1;
    wait_cyc(4);
    sclk = 1'b0;
    if (last_with_rise) strobe_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic open_frame();
    strobe_n = 1'b1; wait_cyc(6);
    strobe_n = 1'b0; wait_cyc(6);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n, input logic rise_on_last);
    for (int i = 0; i < n; i++)
      send_bit(w[31-i], rise_on_last && (i == n-1));
  endtask

  task automatic full_frame(input logic [31:0] w, input string req);
    int p0;
    p0 = pulses;
    open_frame();
    send_bits(w, 32, 1'b0);
    wait_cyc(8);
    strobe_n = 1'b1; wait_cyc(6);
    check(req, pulses - p0, 1);
    check(req, last_word, w);
  endtask

  initial begin
    int p0;
    logic [31:0] lf, held;
    wait_cyc(5);
    check("R1", valid, 0);
    check("R1", word, 0);
    rst_n = 1'b1; wait_cyc(4);
    check("R1", word, 0);

    for (int k = 0; k < 32; k++) full_frame(32'h1 << k, "R2");
    for (int k = 0; k < 32; k++) full_frame(~(32'h1 << k), "R2");
    lf = 32'hACE1_1234;
    for (int k = 0; k < 16; k++) begin
      full_frame(lf, "R3");
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    end

    for (int n = 1; n < 32; n++) begin
      p0 = pulses;
      open_frame();
      send_bits(32'hFFFF_FFFF, n, 1'b0);
      strobe_n = 1'b1; wait_cyc(10);
      check("R4", pulses - p0, 0);
      full_frame(32'h0F0F_0000 | 32'(n), "R4");
    end

    p0 = pulses;
    open_frame();
    send_bits(32'h1357_9BDF, 32, 1'b0);
    wait_cyc(8);
    check("R7", pulses - p0, 1);
    send_bits(32'hFFFF_0000, 8, 1'b0);
    wait_cyc(8);
    check("R5", pulses - p0, 1);
    check("R5", word, 32'h1357_9BDF);
    send_bits(32'h89AB_CDEF, 32, 1'b0);
    wait_cyc(8);
    check("R6", pulses - p0, 1);
    check("R6", word, 32'h1357_9BDF);
    strobe_n = 1'b1; wait_cyc(6);

    p0 = pulses;
    open_frame();
    send_bits(32'hDEAD_BEEF, 32, 1'b1);
    wait_cyc(10);
    check("R7", pulses - p0, 1);
    check("R7", last_word, 32'hDEAD_BEEF);

    strobe_n = 1'b0; rst_n = 1'b0; wait_cyc(3);
    check("R1", word, 0);
    rst_n = 1'b1; wait_cyc(4);
    held = word;
    p0 = pulses;
    send_bits(32'h5555_AAAA, 32, 1'b0);
    wait_cyc(8);
    check("R6", pulses - p0, 0);
    check("R6", word, held);
    full_frame(32'h0123_4567, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule